// File: doc/BRIEF.md
# Recurrent Cell State and Hidden Output Updater

This block does the element-wise part of one recurrent memory step. An upstream matrix-vector engine computes four gate pre-activation vectors from the previous hidden vector joined with the current input vector. It sends them here one value at a time. Each value is tagged with its gate kind and its element index. The block maps every value through a quantized sigmoid or tanh table. It keeps the four activated values for each element. When the last of the four arrives, it computes the new cell value and the new hidden value for that element.

The hidden vector and the cell vector stay in the block between steps. The hidden vector can be read back at any element through a combinational port, so the upstream engine can build the operand for the next step. Each new hidden value also leaves the block on an output stream. A one-cycle completion pulse comes with the last hidden value of a step. A sequence-start strobe sets both stored vectors to zero before a new sequence.

All values are 16-bit signed fixed point with 11 fraction bits (value = code / 2048). The hidden size is 32.

Top module: `lstm_cell_update`

## Requirements
- R1: Gate tags on `in_gate` are 0 = forget, 1 = input, 2 = candidate, 3 = output. The forget, input and output values pass through the sigmoid table. The candidate value passes through the tanh table.
- R2: A table input is first clamped to the codes -8192..8191 (-4.0 up to just below 4.0). The address is (clamped + 8192) >> 4, which gives 1024 entries with a step of 1/128. Entry a holds round(2048 * F((a - 512) / 128)). Any input above 8191 therefore gives exactly the same result as 8191, and any input below -8192 gives the same result as -8192.
- R3: The new cell value is C = sat(floor((f*C_old + i*g + 1024) / 2048)), where sat limits the result to -32768..32767. The sum of the two products is formed at full precision before it is rounded.
- R4: The new hidden value is h = sat(floor((o*tanh_table(C) + 1024) / 2048)). Because both factors are at most 1.0 in magnitude, |h| <= 2048.
- R5: An element is updated only when all four gate kinds for that index have arrived since its last update, in any order. Its hidden value appears on `h_valid`/`h_idx`/`h_data` exactly three cycles after the cycle in which the fourth value was accepted.
- R6: `done` is high for exactly one cycle. It is high together with the 32nd hidden value written since the last completion or the last sequence start.
- R7: `seq_start` sets every stored hidden value and cell value to zero. It discards partly collected gate values and resets the completion count. In the cycle after it, no hidden value is output and every read-back gives 0.
- R8: `hr_data` always shows, without delay, the stored hidden value at element `hr_idx`.
- R9: After reset, `h_valid` and `done` are low and every stored hidden value reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start | input | 1 | Clears the recurrent state for a new sequence |
| in_valid | input | 1 | Gate pre-activation value is present |
| in_gate | input | 2 | Gate kind tag |
| in_idx | input | 5 | Element index of the value |
| in_data | input | 16 | Pre-activation value, Q4.11 |
| hr_idx | input | 5 | Read-back element index |
| hr_data | output | 16 | Stored hidden value at `hr_idx` |
| h_valid | output | 1 | New hidden value present |
| h_idx | output | 5 | Element index of the new hidden value |
| h_data | output | 16 | New hidden value, Q4.11 |
| done | output | 1 | Last hidden value of a step |

## Verification
A wrong arrival flag shows up at the ports within three cycles. It either produces an `h_valid` with no matching fourth gate or drops one that was due. A miscounted step moves the `done` pulse. A corrupted cell value stays hidden until the same element is updated in a later step, so the bench runs consecutive steps without clearing and compares every output cycle against a behavioural model. Separate runs feed the gates in per-element order and in gate-major order, drive table inputs outside the clamp range, and assert the sequence-start strobe halfway through a step.

// File: rtl/lstm_cell_pkg.sv
package lstm_cell_pkg;
   typedef enum logic [1:0] {
      GATE_FORGET = 2'd0,
      GATE_INPUT  = 2'd1,
      GATE_CAND   = 2'd2,
      GATE_OUT    = 2'd3
   } gate_e;
   localparam int NUM_GATES = 4;
endpackage

// File: rtl/lstm_act_rom.sv
module lstm_act_rom #(
   parameter int DW      = 16,
   parameter int FW      = 11,
   parameter int AW      = 10,
   parameter bit IS_TANH = 1'b0
) (
   input  logic                 clk,
   input  logic signed [DW-1:0] x,
   output logic signed [DW-1:0] y
);
   localparam int DEPTH = 1 << AW;
   localparam int SHIFT = FW + 3 - AW;
   localparam int LIM   = 4 << FW;
   localparam int ONE   = 1 << FW;

   if (AW > FW + 3) begin : g_bad_aw
      $error("lstm_act_rom: AW exceeds the clamp range resolution");
   end
   if (DW < FW + 4) begin : g_bad_dw
      $error("lstm_act_rom: DW too narrow for the clamp range");
   end

   function automatic real neg_exp(input real yv);
      real z, term, sum;
      z    = yv / 16.0;
      term = 1.0;
      sum  = 1.0;
      for (int n = 1; n < 14; n++) begin
         term = term * (-z) / real'(n);
         sum  = sum + term;
      end
      for (int s = 0; s < 4; s++) sum = sum * sum;
      return sum;
   endfunction

   function automatic int entry_of(input int a);
      real xr, mag, e, v;
      int  q;
      xr  = real'(a - DEPTH / 2) / real'(DEPTH / 8);
      mag = (xr < 0.0) ? -xr : xr;
      if (IS_TANH) begin
         e = neg_exp(2.0 * mag);
         v = (1.0 - e) / (1.0 + e);
      end else begin
         e = neg_exp(mag);
         v = (xr < 0.0) ? e / (1.0 + e) : 1.0 / (1.0 + e);
      end
      q = $rtoi(v * real'(ONE) + 0.5);
      if (IS_TANH && xr < 0.0) q = -q;
      return q;
   endfunction

   logic signed [DW-1:0] tbl [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_tbl
      localparam int V = entry_of(a);
      assign tbl[a] = V[DW-1:0];
   end

   int          off;
   logic [AW-1:0] addr;

   always_comb begin
      off = int'(x) + LIM;
      if (off < 0) off = 0;
      else if (off > 2 * LIM - 1) off = 2 * LIM - 1;
      addr = off[AW+SHIFT-1:SHIFT];
   end

   always_ff @(posedge clk) y <= tbl[addr];
endmodule

// File: rtl/lstm_fx_mac.sv
module lstm_fx_mac #(
   parameter int DW = 16,
   parameter int FW = 11
) (
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   input  logic signed [DW-1:0] c,
   input  logic signed [DW-1:0] d,
   output logic signed [DW-1:0] y
);
   localparam int PW = 2 * DW + 1;

   logic signed [PW-1:0] pa, pb, pc, pd, acc, sh;

   always_comb begin
      pa  = PW'(a);
      pb  = PW'(b);
      pc  = PW'(c);
      pd  = PW'(d);
      acc = pa * pb + pc * pd + (PW'(1) <<< (FW - 1));
      sh  = acc >>> FW;
      if (sh[PW-1:DW-1] != {(PW-DW+1){sh[PW-1]}})
         y = {sh[PW-1], {(DW-1){~sh[PW-1]}}};
      else
         y = sh[DW-1:0];
   end
endmodule

// File: rtl/lstm_cell_update.sv
module lstm_cell_update
   import lstm_cell_pkg::*;
#(
   parameter  int DW     = 16,
   parameter  int FW     = 11,
   parameter  int HID    = 32,
   parameter  int LUT_AW = 10,
   localparam int IW     = $clog2(HID),
   localparam int CW     = IW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 seq_start,
   input  logic                 in_valid,
   input  logic [1:0]           in_gate,
   input  logic [IW-1:0]        in_idx,
   input  logic signed [DW-1:0] in_data,
   input  logic [IW-1:0]        hr_idx,
   output logic signed [DW-1:0] hr_data,
   output logic                 h_valid,
   output logic [IW-1:0]        h_idx,
   output logic signed [DW-1:0] h_data,
   output logic                 done
);
   if (HID < 2 || (1 << IW) != HID) begin : g_bad_hid
      $error("lstm_cell_update: HID must be a power of two of at least 2");
   end

   // stage 1: table outputs registered together with the tag
   logic                 s1_v;
   gate_e                s1_gate;
   logic [IW-1:0]        s1_idx;
   logic signed [DW-1:0] sig_q, tnh_q, act1;

   lstm_act_rom #(.DW(DW), .FW(FW), .AW(LUT_AW), .IS_TANH(1'b0)) u_sig_rom (
      .clk(clk), .x(in_data), .y(sig_q));
   lstm_act_rom #(.DW(DW), .FW(FW), .AW(LUT_AW), .IS_TANH(1'b1)) u_tnh_rom (
      .clk(clk), .x(in_data), .y(tnh_q));

   assign act1 = (s1_gate == GATE_CAND) ? tnh_q : sig_q;

   // per-element gate store and arrival flags
   logic signed [DW-1:0] gs   [NUM_GATES][HID];
   logic [NUM_GATES-1:0] have [HID];
   logic [NUM_GATES-1:0] have_now;
   logic                 launch;
   logic signed [DW-1:0] opv  [NUM_GATES];

   always_comb begin
      have_now = have[s1_idx] | (NUM_GATES'(1) << s1_gate);
      launch   = s1_v && (&have_now);
      for (int k = 0; k < NUM_GATES; k++)
         opv[k] = (s1_gate == gate_e'(k)) ? act1 : gs[k][s1_idx];
   end

   always_ff @(posedge clk) begin
      if (s1_v) gs[s1_gate][s1_idx] <= act1;
   end

   // cell update and second tanh lookup
   logic signed [DW-1:0] cst [HID];
   logic signed [DW-1:0] hst [HID];
   logic signed [DW-1:0] c_new, ct_q, h_new;
   logic                 s2_v;
   logic [IW-1:0]        s2_idx;
   logic signed [DW-1:0] s2_o;
   logic [CW-1:0]        cnt;

   lstm_fx_mac #(.DW(DW), .FW(FW)) u_cell_mac (
      .a(opv[GATE_FORGET]), .b(cst[s1_idx]),
      .c(opv[GATE_INPUT]),  .d(opv[GATE_CAND]), .y(c_new));

   lstm_act_rom #(.DW(DW), .FW(FW), .AW(LUT_AW), .IS_TANH(1'b1)) u_cell_rom (
      .clk(clk), .x(c_new), .y(ct_q));

   lstm_fx_mac #(.DW(DW), .FW(FW)) u_hid_mac (
      .a(s2_o), .b(ct_q), .c('0), .d('0), .y(h_new));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_gate <= GATE_FORGET;
         s1_idx  <= '0;
         s2_v    <= 1'b0;
         s2_idx  <= '0;
         s2_o    <= '0;
         h_valid <= 1'b0;
         h_idx   <= '0;
         h_data  <= '0;
         done    <= 1'b0;
         cnt     <= '0;
         for (int k = 0; k < HID; k++) begin
            have[k] <= '0;
            cst[k]  <= '0;
            hst[k]  <= '0;
         end
      end else if (seq_start) begin
         s1_v    <= 1'b0;
         s2_v    <= 1'b0;
         h_valid <= 1'b0;
         done    <= 1'b0;
         cnt     <= '0;
         for (int k = 0; k < HID; k++) begin
            have[k] <= '0;
            cst[k]  <= '0;
            hst[k]  <= '0;
         end
      end else begin
         s1_v    <= in_valid;
         s1_gate <= gate_e'(in_gate);
         s1_idx  <= in_idx;
         s2_v    <= launch;
         if (s1_v) have[s1_idx] <= launch ? '0 : have_now;
         if (launch) begin
            cst[s1_idx] <= c_new;
            s2_idx      <= s1_idx;
            s2_o        <= opv[GATE_OUT];
         end
         h_valid <= s2_v;
         done    <= 1'b0;
         if (s2_v) begin
            hst[s2_idx] <= h_new;
            h_idx       <= s2_idx;
            h_data      <= h_new;
            if (cnt == CW'(HID - 1)) begin
               cnt  <= '0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign hr_data = hst[hr_idx];
endmodule

// File: rtl/lstm_cell_update_chk.sv
module lstm_cell_update_chk #(
   parameter int DW = 16,
   parameter int FW = 11,
   parameter int IW = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 seq_start,
   input logic                 in_valid,
   input logic signed [DW-1:0] hr_data,
   input logic                 h_valid,
   input logic signed [DW-1:0] h_data,
   input logic                 done
);
   localparam int ONE = 1 << FW;

   AST_H_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      h_valid |-> $past(in_valid, 3)); // R5

   AST_H_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      h_valid |-> (int'(h_data) <= ONE && int'(h_data) >= -ONE)); // R4

   AST_DONE_WITH_H: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> h_valid); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(seq_start) |-> (!h_valid && hr_data == '0)); // R7
endmodule

bind lstm_cell_update lstm_cell_update_chk #(.DW(DW), .FW(FW), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .in_valid(in_valid),
   .hr_data(hr_data), .h_valid(h_valid), .h_data(h_data), .done(done));

// File: tb/lstm_cell_update_test.sv
module lstm_cell_update_test;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               seq_start = 1'b0;
   logic               in_valid = 1'b0;
   logic [1:0]         in_gate = '0;
   logic [4:0]         in_idx = '0;
   logic signed [15:0] in_data = '0;
   logic [4:0]         hr_idx = '0;
   logic signed [15:0] hr_data;
   logic               h_valid;
   logic [4:0]         h_idx;
   logic signed [15:0] h_data;
   logic               done;

   always #5 clk = ~clk;

   lstm_cell_update uut (
      .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .in_valid(in_valid),
      .in_gate(in_gate), .in_idx(in_idx), .in_data(in_data), .hr_idx(hr_idx),
      .hr_data(hr_data), .h_valid(h_valid), .h_idx(h_idx), .h_data(h_data),
      .done(done));

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int seed = 7;
   bit finished = 0;

   // behavioural reference state
   int h_m [32];
   int c_m [32];
   int gv  [4][32];
   bit hv  [4][32];
   int step_cnt = 0;
   typedef struct { int due; int idx; int val; bit dn; } exp_t;
   exp_t q [$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   function automatic int lut(input bit is_tanh, input int v);
      int  c, a, m;
      real x, ax, e, r;
      c  = (v < -8192) ? -8192 : ((v > 8191) ? 8191 : v);
      a  = (c + 8192) >> 4;
      x  = real'(a - 512) / 128.0;
      ax = (x < 0.0) ? -x : x;
      if (is_tanh) begin
         e = $exp(-2.0 * ax);
         r = (1.0 - e) / (1.0 + e);
         m = $rtoi(r * 2048.0 + 0.5);
         return (x < 0.0) ? -m : m;
      end
      e = $exp(-ax);
      r = (x < 0.0) ? e / (1.0 + e) : 1.0 / (1.0 + e);
      return $rtoi(r * 2048.0 + 0.5);
   endfunction

   function automatic int fx(input int a, input int b, input int c, input int d);
      longint s;
      s = longint'(a) * b + longint'(c) * d + 1024;
      s = s >>> 11;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return int'(s);
   endfunction

   function automatic int rnd(input int span);
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 8) & 32'h7fffff) % (2 * span) - span;
   endfunction

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   // reference update on acceptance of one gate value (R1, R3, R4, R5, R6)
   task automatic model_gate(input int g, input int idx, input int v);
      int cn, hn;
      exp_t e;
      gv[g][idx] = lut(g == 2, v);
      hv[g][idx] = 1'b1;
      if (hv[0][idx] && hv[1][idx] && hv[2][idx] && hv[3][idx]) begin
         cn = fx(gv[0][idx], c_m[idx], gv[1][idx], gv[2][idx]);
         hn = fx(gv[3][idx], lut(1'b1, cn), 0, 0);
         c_m[idx] = cn;
         h_m[idx] = hn;
         step_cnt++;
         e.due = cyc + 3; e.idx = idx; e.val = hn; e.dn = (step_cnt == 32);
         if (e.dn) step_cnt = 0;
         q.push_back(e);
         for (int k = 0; k < 4; k++) hv[k][idx] = 1'b0;
      end
   endtask

   task automatic drive(input int g, input int idx, input int v);
      @(negedge clk);
      in_valid = 1'b1;
      in_gate  = 2'(g);
      in_idx   = 5'(idx);
      in_data  = 16'(v);
      model_gate(g, idx, v);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic start_seq();
      @(negedge clk);
      in_valid  = 1'b0;
      seq_start = 1'b1;
      for (int k = 0; k < 32; k++) begin
         h_m[k] = 0; c_m[k] = 0;
         for (int g = 0; g < 4; g++) hv[g][k] = 1'b0;
      end
      step_cnt = 0;
      @(negedge clk);
      seq_start = 1'b0;
   endtask

   task automatic check_readback(input string req);
      for (int k = 0; k < 32; k++) begin
         hr_idx = 5'(k);
         #1;
         check(iabs(int'(hr_data) - h_m[k]) <= 2, req, int'(hr_data), h_m[k]);
      end
   endtask

   // per-cycle comparison of the output stream against the reference queue
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         while (q.size() > 0 && q[0].due < cyc) begin
            check(1'b0, "R5", 0, q[0].idx);
            void'(q.pop_front());
         end
         if (q.size() > 0 && q[0].due == cyc) begin
            check(h_valid == 1'b1, "R5", int'(h_valid), 1);
            check(int'(h_idx) == q[0].idx, "R5", int'(h_idx), q[0].idx);
            check(iabs(int'(h_data) - q[0].val) <= 2, "R4", int'(h_data), q[0].val);
            check(done == q[0].dn, "R6", int'(done), int'(q[0].dn));
            void'(q.pop_front());
         end else begin
            check(h_valid == 1'b0, "R5", int'(h_valid), 0);
            check(done == 1'b0, "R6", int'(done), 0);
         end
      end
   end

   initial begin
      int r0, r1;
      for (int k = 0; k < 32; k++) begin
         h_m[k] = 0; c_m[k] = 0;
         for (int g = 0; g < 4; g++) begin gv[g][k] = 0; hv[g][k] = 1'b0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(h_valid == 1'b0, "R9", int'(h_valid), 0);
      check(done == 1'b0, "R9", int'(done), 0);
      check_readback("R9");

      // step 1: per-element gate order forget, input, candidate, output (R1, R3)
      for (int k = 0; k < 32; k++)
         for (int g = 0; g < 4; g++) drive(g, k, rnd(12288));
      idle(5);
      check_readback("R8");

      // step 2: gate-major order with output first; cell value carries over (R5, R3)
      for (int g = 3; g >= 0; g--)
         for (int k = 0; k < 32; k++) drive(g, (k * 7) % 32, rnd(12288));
      idle(5);
      check_readback("R8");

      // step 3: reverse element order, another carried step (R3, R6)
      for (int k = 31; k >= 0; k--)
         for (int g = 0; g < 4; g++) drive((g + k) % 4, k, rnd(20000));
      idle(5);
      check_readback("R8");

      // clamp range: out-of-range inputs equal the edge inputs (R2)
      start_seq();
      for (int g = 0; g < 4; g++) drive(g, 0, 32767);
      for (int g = 0; g < 4; g++) drive(g, 1, 8191);
      for (int g = 0; g < 4; g++) drive(g, 2, -32768);
      for (int g = 0; g < 4; g++) drive(g, 3, -8192);
      idle(5);
      hr_idx = 5'd0; #1; r0 = int'(hr_data);
      hr_idx = 5'd1; #1; r1 = int'(hr_data);
      check(r0 == r1, "R2", r0, r1);
      hr_idx = 5'd2; #1; r0 = int'(hr_data);
      hr_idx = 5'd3; #1; r1 = int'(hr_data);
      check(r0 == r1, "R2", r0, r1);
      for (int k = 4; k < 32; k++)
         for (int g = 0; g < 4; g++) drive(g, k, rnd(30000));
      idle(5);
      check_readback("R2");

      // sequence start in the middle of a step (R7)
      for (int k = 0; k < 6; k++)
         for (int g = 0; g < 4; g++) drive(g, k, rnd(12288));
      drive(0, 9, 3000);
      drive(1, 9, 3000);
      idle(5);
      start_seq();
      check(h_valid == 1'b0, "R7", int'(h_valid), 0);
      check_readback("R7");
      drive(2, 9, 4000);
      drive(3, 9, 4000);
      idle(5);
      check_readback("R7");
      drive(0, 9, 1000);
      drive(1, 9, 2000);
      idle(5);
      check_readback("R8");
      for (int k = 0; k < 32; k++)
         if (k != 9) for (int g = 0; g < 4; g++) drive(3 - g, k, rnd(12288));
      idle(6);
      check_readback("R6");
      check(q.size() == 0, "R5", q.size(), 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule